// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block gives two processors, called side A and side B, a way to pass short messages and to signal each other. Each side owns four 16-bit message slots. It can write them a byte at a time and read them back. The opposite side can only read them. A write that touches the upper byte of a slot raises an interrupt source on the opposite side. The receiver acknowledges that source by reading the upper byte of the same slot, and the read leaves the message intact. Each side has one control word. It holds a four-bit mask, a post-mask cause field and a pre-mask status field, and it drives an active-low interrupt output.

All accesses are synchronous to one clock. A side requests an access by raising its select for at least one cycle. Each side runs a two-state access machine:
- **PS_IDLE** waits for a select.
- The **ACCEPT** transition (PS_IDLE to PS_BUSY, taken when select is high) is the only cycle in which the access acts. In that cycle a write lands, a source is set or cleared, and read data is captured.
- **PS_BUSY** holds while select stays high and has no further effect.
- The **RELEASE** transition (PS_BUSY to PS_IDLE) occurs when select drops.

Read data appears on the read-data output in the cycle after ACCEPT and holds until the next accepted read.

Top module: `mbx_dual_irq`

## Requirements
- R1: After reset the mask is 4'b1111, no source is pending, both interrupt outputs are high, every message slot reads 16'h0000, and the control word reads 16'h0FFF.
- R2: Addresses 6'h20 to 6'h23 select the side's own slots 0 to 3. A write stores bits 15:8 when the upper enable is high and bits 7:0 when the lower enable is high, and the other byte is kept. A read at these addresses returns the stored word.
- R3: A write to own slot i with the upper enable high sets source i on the opposite side. A write with only the lower enable high sets no source.
- R4: Addresses 6'h24 to 6'h27 return the opposite side's slots 0 to 3. A read with the upper enable high clears source i in both the cause and the status fields and leaves the slot data unchanged. A read with only the lower enable high clears nothing.
- R5: A side reading back its own slot, with either enable, does not change the source it raised on the opposite side.
- R6: Address 6'h28 is the control word. Bits 3:0 are the mask, where 1 disables slot i. Bits 7:4 are cause and bits 11:8 are status, and in both fields a pending source reads as 0. Bits 15:12 read 0. A write with the lower enable high replaces all four mask bits at once. A write never alters cause or status, and a write with only the upper enable high leaves the mask unchanged.
- R7: A source that arrives while its mask bit is 1 sets its status bit but not its cause bit, and it does not drive the interrupt output.
- R8: The interrupt output of a side is low exactly while at least one of its cause bits is pending.
- R9: A write to any other address (6'h00 to 6'h1F, 6'h29 to 6'h3F) changes no slot, no mask and no source.
- R10: An access acts once per select assertion, in its first cycle. Holding select high repeats no write or clear, and the read data stays stable.
- R11: When a set and a clear of the same source fall in the same cycle, the source ends up pending.
- R12: A mask write by one side leaves the other side's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access select |
| a_addr | input | 6 | Side A register address |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_be_hi | input | 1 | Side A upper byte enable |
| a_be_lo | input | 1 | Side A lower byte enable |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data, registered |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_sel | input | 1 | Side B access select |
| b_addr | input | 6 | Side B register address |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_be_hi | input | 1 | Side B upper byte enable |
| b_be_lo | input | 1 | Side B lower byte enable |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data, registered |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
The assertions guard every cycle:
- a pending cause never exists without its status bit;
- a set always leaves its source pending, even against a clear in the same cycle;
- a lone clear empties both fields;
- a masked arrival never creates a cause;
- slot data and the mask move only on an accepted write;
- nothing acts or changes read data while an access is held in PS_BUSY.

Only the directed scenarios can show the address map and the byte merging, the active-low field encoding seen through the control word, and the interrupt output following cause. They also show that reserved writes and own read-backs leave the other side undisturbed, and that a source raised during a held acknowledge survives it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DATA_W = 16;
    localparam int MBX_NUM    = 4;
    localparam int MBX_ADDR_W = 6;

    typedef enum logic [1:0] {
        ACC_RSVD = 2'd0,
        ACC_OWN  = 2'd1,
        ACC_PEER = 2'd2,
        ACC_CTRL = 2'd3
    } acc_kind_e;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_BUSY = 1'b1
    } port_state_e;

    // Address map: 0x20-0x23 own slots, 0x24-0x27 peer slots, 0x28 control word.
    function automatic acc_kind_e decode_kind(input logic [MBX_ADDR_W-1:0] a);
        acc_kind_e k;
        if (a[5:2] == 4'b1000)
            k = ACC_OWN;
        else if (a[5:2] == 4'b1001)
            k = ACC_PEER;
        else if (a == 6'h28)
            k = ACC_CTRL;
        else
            k = ACC_RSVD;
        return k;
    endfunction

endpackage

// File: rtl/mbx_port_ctl.sv
module mbx_port_ctl
    import mbx_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W,
    parameter int N_MBX  = MBX_NUM,
    parameter int ADDR_W = MBX_ADDR_W,
    localparam int IDX_W = $clog2(N_MBX)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic                        be_hi,
    input  logic                        be_lo,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [N_MBX-1:0][DATA_W-1:0] own_words,
    input  logic [N_MBX-1:0][DATA_W-1:0] peer_words,
    input  logic [DATA_W-1:0]           ctrl_word,
    output logic                        own_wr_en,
    output logic [IDX_W-1:0]            own_wr_idx,
    output logic [1:0]                  own_wr_be,
    output logic [DATA_W-1:0]           own_wr_data,
    output logic                        mask_wr_en,
    output logic [N_MBX-1:0]            mask_wr_data,
    output logic [N_MBX-1:0]            clr_vec,
    output logic [DATA_W-1:0]           rdata
);

    port_state_e state, state_nx;
    acc_kind_e   kind;
    logic [IDX_W-1:0] idx;
    logic        accept;
    logic        rd_load;
    logic [DATA_W-1:0] rd_next;

    assign kind = decode_kind(addr);
    assign idx  = addr[IDX_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PS_IDLE;
        else
            state <= state_nx;
    end

    // Transitions: ACCEPT (idle->busy) and RELEASE (busy->idle)
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: state_nx = sel ? PS_BUSY : PS_IDLE;
            PS_BUSY: state_nx = sel ? PS_BUSY : PS_IDLE;
        endcase
    end

    // Outputs: effects only on the ACCEPT cycle
    always_comb begin
        accept       = (state == PS_IDLE) && sel;
        own_wr_en    = accept && wr && (kind == ACC_OWN) && (be_hi || be_lo);
        own_wr_idx   = idx;
        own_wr_be    = {be_hi, be_lo};
        own_wr_data  = wdata;
        mask_wr_en   = accept && wr && (kind == ACC_CTRL) && be_lo;
        mask_wr_data = wdata[N_MBX-1:0];
        clr_vec      = '0;
        if (accept && !wr && (kind == ACC_PEER) && be_hi)
            clr_vec = N_MBX'(1) << idx;
        rd_load      = accept && !wr;
        rd_next      = '0;
        unique case (kind)
            ACC_OWN:  rd_next = own_words[idx];
            ACC_PEER: rd_next = peer_words[idx];
            ACC_CTRL: rd_next = ctrl_word;
            ACC_RSVD: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_load)
            rdata <= rd_next;
    end

    assert_busy_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BUSY) |-> (!own_wr_en && !mask_wr_en && clr_vec == '0))
        else $error("held access produced an effect");

    assert_busy_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BUSY) |=> $stable(rdata))
        else $error("read data moved during held access");

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W,
    parameter int N_MBX  = MBX_NUM,
    localparam int IDX_W = $clog2(N_MBX),
    localparam int HALF  = DATA_W / 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [1:0]                   wr_be,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [N_MBX-1:0][DATA_W-1:0] words
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (wr_en) begin
            if (wr_be[1])
                words[wr_idx][DATA_W-1:HALF] <= wr_data[DATA_W-1:HALF];
            if (wr_be[0])
                words[wr_idx][HALF-1:0] <= wr_data[HALF-1:0];
        end
    end

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words))
        else $error("slot data changed without a write");

    assert_lower_keeps_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[1]) |=>
            words[$past(wr_idx)][DATA_W-1:HALF] == $past(words[wr_idx][DATA_W-1:HALF]))
        else $error("upper byte changed on lower-only write");

endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank
    import mbx_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W,
    parameter int N_MBX  = MBX_NUM,
    localparam int PAD_W = DATA_W - 3 * N_MBX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MBX-1:0]  set_vec,
    input  logic [N_MBX-1:0]  clr_vec,
    input  logic              mask_wr_en,
    input  logic [N_MBX-1:0]  mask_wdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              irq_n
);

    logic [N_MBX-1:0] mask;
    logic [N_MBX-1:0] cause;
    logic [N_MBX-1:0] status;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '1;
        else if (mask_wr_en)
            mask <= mask_wdata;
    end

    // Set has priority over clear; cause only for unmasked sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            cause  <= '0;
        end else begin
            for (int i = 0; i < N_MBX; i++) begin
                if (set_vec[i]) begin
                    status[i] <= 1'b1;
                    if (!mask[i])
                        cause[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    status[i] <= 1'b0;
                    cause[i]  <= 1'b0;
                end
            end
        end
    end

    assign ctrl_word = {{PAD_W{1'b0}}, ~status, ~cause, mask};
    assign irq_n     = ~|cause;

    for (genvar i = 0; i < N_MBX; i++) begin : g_chk
        assert_cause_needs_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cause[i] |-> status[i])
            else $error("cause without status");

        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> status[i])
            else $error("set lost");

        assert_clear_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> (!status[i] && !cause[i]))
            else $error("clear incomplete");

        assert_masked_no_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && mask[i] && !cause[i]) |=> !cause[i])
            else $error("masked source raised cause");
    end

    assert_mask_only_on_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_en |=> $stable(mask))
        else $error("mask changed without write");

endmodule

// File: rtl/mbx_dual_irq.sv
module mbx_dual_irq
    import mbx_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W,
    parameter int N_MBX  = MBX_NUM,
    parameter int ADDR_W = MBX_ADDR_W,
    localparam int IDX_W = $clog2(N_MBX),
    localparam int N_SIDE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic              a_be_hi,
    input  logic              a_be_lo,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_sel,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic              b_be_hi,
    input  logic              b_be_lo,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    logic                         sel_w      [N_SIDE];
    logic [ADDR_W-1:0]            addr_w     [N_SIDE];
    logic                         wr_w       [N_SIDE];
    logic                         be_hi_w    [N_SIDE];
    logic                         be_lo_w    [N_SIDE];
    logic [DATA_W-1:0]            wdata_w    [N_SIDE];
    logic [DATA_W-1:0]            rdata_w    [N_SIDE];
    logic                         irq_n_w    [N_SIDE];
    logic [N_MBX-1:0][DATA_W-1:0] words_w    [N_SIDE];
    logic [DATA_W-1:0]            ctrl_w     [N_SIDE];
    logic                         own_wr_en_w[N_SIDE];
    logic [IDX_W-1:0]             own_idx_w  [N_SIDE];
    logic [1:0]                   own_be_w   [N_SIDE];
    logic [DATA_W-1:0]            own_data_w [N_SIDE];
    logic                         mask_we_w  [N_SIDE];
    logic [N_MBX-1:0]             mask_wd_w  [N_SIDE];
    logic [N_MBX-1:0]             clr_w      [N_SIDE];
    logic [N_MBX-1:0]             set_w      [N_SIDE];

    assign sel_w[0]   = a_sel;    assign sel_w[1]   = b_sel;
    assign addr_w[0]  = a_addr;   assign addr_w[1]  = b_addr;
    assign wr_w[0]    = a_wr;     assign wr_w[1]    = b_wr;
    assign be_hi_w[0] = a_be_hi;  assign be_hi_w[1] = b_be_hi;
    assign be_lo_w[0] = a_be_lo;  assign be_lo_w[1] = b_be_lo;
    assign wdata_w[0] = a_wdata;  assign wdata_w[1] = b_wdata;
    assign a_rdata    = rdata_w[0];
    assign b_rdata    = rdata_w[1];
    assign a_irq_n    = irq_n_w[0];
    assign b_irq_n    = irq_n_w[1];

    for (genvar p = 0; p < N_SIDE; p++) begin : g_side
        localparam int OPP = 1 - p;

        mbx_port_ctl #(.DATA_W(DATA_W), .N_MBX(N_MBX), .ADDR_W(ADDR_W)) u_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (sel_w[p]),
            .addr         (addr_w[p]),
            .wr           (wr_w[p]),
            .be_hi        (be_hi_w[p]),
            .be_lo        (be_lo_w[p]),
            .wdata        (wdata_w[p]),
            .own_words    (words_w[p]),
            .peer_words   (words_w[OPP]),
            .ctrl_word    (ctrl_w[p]),
            .own_wr_en    (own_wr_en_w[p]),
            .own_wr_idx   (own_idx_w[p]),
            .own_wr_be    (own_be_w[p]),
            .own_wr_data  (own_data_w[p]),
            .mask_wr_en   (mask_we_w[p]),
            .mask_wr_data (mask_wd_w[p]),
            .clr_vec      (clr_w[p]),
            .rdata        (rdata_w[p])
        );

        mbx_store #(.DATA_W(DATA_W), .N_MBX(N_MBX)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (own_wr_en_w[p]),
            .wr_idx  (own_idx_w[p]),
            .wr_be   (own_be_w[p]),
            .wr_data (own_data_w[p]),
            .words   (words_w[p])
        );

        // Sources for this side are raised by the opposite side's upper-byte writes.
        assign set_w[p] = (own_wr_en_w[OPP] && own_be_w[OPP][1])
                        ? (N_MBX'(1) << own_idx_w[OPP]) : '0;

        mbx_irq_bank #(.DATA_W(DATA_W), .N_MBX(N_MBX)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_vec    (set_w[p]),
            .clr_vec    (clr_w[p]),
            .mask_wr_en (mask_we_w[p]),
            .mask_wdata (mask_wd_w[p]),
            .ctrl_word  (ctrl_w[p]),
            .irq_n      (irq_n_w[p])
        );
    end

endmodule

// File: tb/tb_mbx_dual_irq.sv
module tb_mbx_dual_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 0, a_wr = 0, a_be_hi = 0, a_be_lo = 0;
    logic [5:0]  a_addr = '0;
    logic [15:0] a_wdata = '0;
    logic [15:0] a_rdata;
    logic        a_irq_n;
    logic        b_sel = 0, b_wr = 0, b_be_hi = 0, b_be_lo = 0;
    logic [5:0]  b_addr = '0;
    logic [15:0] b_wdata = '0;
    logic [15:0] b_rdata;
    logic        b_irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbx_dual_irq dut (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_addr(a_addr), .a_wr(a_wr), .a_be_hi(a_be_hi),
        .a_be_lo(a_be_lo), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_sel(b_sel), .b_addr(b_addr), .b_wr(b_wr), .b_be_hi(b_be_hi),
        .b_be_lo(b_be_lo), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drv(input int p, input logic s, input logic [5:0] ad, input logic w,
                       input logic hi, input logic lo, input logic [15:0] d);
        if (p == 0) begin
            a_sel = s; a_addr = ad; a_wr = w; a_be_hi = hi; a_be_lo = lo; a_wdata = d;
        end else begin
            b_sel = s; b_addr = ad; b_wr = w; b_be_hi = hi; b_be_lo = lo; b_wdata = d;
        end
    endtask

    task automatic access(input int p, input logic [5:0] ad, input logic w, input logic hi,
                          input logic lo, input logic [15:0] d, output logic [15:0] rd);
        @(negedge clk);
        drv(p, 1'b1, ad, w, hi, lo, d);
        @(negedge clk);
        drv(p, 1'b0, ad, 1'b0, 1'b0, 1'b0, 16'h0);
        rd = (p == 0) ? a_rdata : b_rdata;
    endtask

    task automatic wr(input int p, input logic [5:0] ad, input logic hi, input logic lo,
                      input logic [15:0] d);
        logic [15:0] unused_rd;
        access(p, ad, 1'b1, hi, lo, d, unused_rd);
    endtask

    task automatic rd_chk(input int p, input logic [5:0] ad, input logic hi, input logic lo,
                          input logic [15:0] exp, input string tag);
        logic [15:0] got;
        access(p, ad, 1'b0, hi, lo, 16'h0, got);
        check(tag, got, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drv(0, 0, 6'h0, 0, 0, 0, 16'h0);
        drv(1, 0, 6'h0, 0, 0, 0, 16'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 a_irq_n", {15'h0, a_irq_n}, 16'h1);
        check("R1 b_irq_n", {15'h0, b_irq_n}, 16'h1);
        rd_chk(0, 6'h28, 1, 1, 16'h0FFF, "R1 A ctrl");
        rd_chk(1, 6'h28, 1, 1, 16'h0FFF, "R1 B ctrl");
        for (int i = 0; i < 4; i++) rd_chk(0, 6'h20 + 6'(i), 1, 1, 16'h0000, "R1 A slot");
    endtask

    task automatic t_bytes();
        do_reset();
        wr(0, 6'h20, 1, 1, 16'h1234);
        wr(0, 6'h21, 0, 1, 16'h55AB);
        wr(0, 6'h21, 1, 0, 16'hCD77);
        rd_chk(0, 6'h21, 1, 1, 16'hCDAB, "R2 byte merge");
        rd_chk(0, 6'h20, 1, 1, 16'h1234, "R2 full word");
        rd_chk(1, 6'h24, 1, 1, 16'h1234, "R4 peer data");
    endtask

    task automatic t_set_clear();
        do_reset();
        wr(1, 6'h28, 0, 1, 16'h0000);
        wr(0, 6'h22, 0, 1, 16'h0011);
        rd_chk(1, 6'h28, 1, 1, 16'h0FF0, "R3 lower write no source");
        check("R3 b_irq_n idle", {15'h0, b_irq_n}, 16'h1);
        wr(0, 6'h22, 1, 0, 16'h2200);
        check("R8 b_irq_n asserted", {15'h0, b_irq_n}, 16'h0);
        check("R3 a_irq_n untouched", {15'h0, a_irq_n}, 16'h1);
        rd_chk(1, 6'h28, 1, 1, 16'h0BB0, "R6 cause/status encoding");
        rd_chk(1, 6'h26, 0, 1, 16'h2211, "R4 lower read data");
        rd_chk(1, 6'h28, 1, 1, 16'h0BB0, "R4 lower read keeps source");
        rd_chk(1, 6'h26, 1, 1, 16'h2211, "R4 upper read data");
        rd_chk(1, 6'h28, 1, 1, 16'h0FF0, "R4 upper read clears");
        check("R8 b_irq_n released", {15'h0, b_irq_n}, 16'h1);
        rd_chk(0, 6'h22, 1, 1, 16'h2211, "R4 data unchanged");
    endtask

    task automatic t_own_readback();
        do_reset();
        wr(1, 6'h28, 0, 1, 16'h0000);
        wr(0, 6'h23, 1, 0, 16'hAA00);
        rd_chk(0, 6'h23, 1, 1, 16'hAA00, "R5 own readback data");
        rd_chk(1, 6'h28, 1, 1, 16'h0770, "R5 source kept after own readback");
        check("R5 b_irq_n still low", {15'h0, b_irq_n}, 16'h0);
    endtask

    task automatic t_mask();
        do_reset();
        wr(1, 6'h28, 1, 1, 16'hF0F2);
        rd_chk(1, 6'h28, 1, 1, 16'h0FF2, "R6 mask write only");
        wr(0, 6'h21, 1, 0, 16'h0100);
        rd_chk(1, 6'h28, 1, 1, 16'h0DF2, "R7 masked status only");
        check("R7 masked no irq", {15'h0, b_irq_n}, 16'h1);
        wr(0, 6'h20, 1, 0, 16'h0100);
        rd_chk(1, 6'h28, 1, 1, 16'h0CE2, "R7 unmasked cause");
        check("R8 irq from unmasked", {15'h0, b_irq_n}, 16'h0);
    endtask

    task automatic t_mask_side();
        do_reset();
        wr(0, 6'h28, 0, 1, 16'h0005);
        rd_chk(0, 6'h28, 1, 1, 16'h0FF5, "R12 own mask");
        rd_chk(1, 6'h28, 1, 1, 16'h0FFF, "R12 other mask untouched");
        wr(0, 6'h28, 1, 0, 16'h0000);
        rd_chk(0, 6'h28, 1, 1, 16'h0FF5, "R6 upper-only keeps mask");
    endtask

    task automatic t_reserved();
        do_reset();
        wr(0, 6'h00, 1, 1, 16'hFFFF);
        wr(0, 6'h2C, 1, 1, 16'hFFFF);
        wr(0, 6'h29, 1, 1, 16'h0000);
        wr(0, 6'h3F, 1, 1, 16'hFFFF);
        wr(0, 6'h24, 1, 1, 16'hBEEF);
        rd_chk(0, 6'h28, 1, 1, 16'h0FFF, "R9 own ctrl untouched");
        rd_chk(1, 6'h28, 1, 1, 16'h0FFF, "R9 no source raised");
        for (int i = 0; i < 4; i++) begin
            rd_chk(0, 6'h20 + 6'(i), 1, 1, 16'h0000, "R9 A slots untouched");
            rd_chk(1, 6'h20 + 6'(i), 1, 1, 16'h0000, "R9 B slots untouched");
        end
    endtask

    task automatic t_hold();
        do_reset();
        wr(1, 6'h28, 0, 1, 16'h0000);
        wr(0, 6'h20, 1, 0, 16'h0100);
        @(negedge clk);
        drv(1, 1, 6'h24, 0, 1, 1, 16'h0);
        @(negedge clk);
        check("R10 rdata after accept", b_rdata, 16'h0100);
        drv(0, 1, 6'h20, 1, 1, 0, 16'h0300);
        @(negedge clk);
        drv(0, 0, 6'h0, 0, 0, 0, 16'h0);
        @(negedge clk);
        check("R10 rdata held", b_rdata, 16'h0100);
        drv(1, 0, 6'h0, 0, 0, 0, 16'h0);
        rd_chk(1, 6'h28, 1, 1, 16'h0EE0, "R10 held read clears once");
        rd_chk(1, 6'h24, 1, 1, 16'h0300, "R10 new data visible");
    endtask

    task automatic t_collision();
        do_reset();
        wr(1, 6'h28, 0, 1, 16'h0000);
        wr(0, 6'h21, 1, 0, 16'h0100);
        @(negedge clk);
        drv(0, 1, 6'h21, 1, 1, 0, 16'h0200);
        drv(1, 1, 6'h25, 0, 1, 1, 16'h0);
        @(negedge clk);
        drv(0, 0, 6'h0, 0, 0, 0, 16'h0);
        drv(1, 0, 6'h0, 0, 0, 0, 16'h0);
        rd_chk(1, 6'h28, 1, 1, 16'h0DD0, "R11 set wins over clear");
        check("R11 irq stays low", {15'h0, b_irq_n}, 16'h0);
        rd_chk(1, 6'h25, 1, 1, 16'h0200, "R11 later clear read");
        rd_chk(1, 6'h28, 1, 1, 16'h0FF0, "R11 later clear effective");
    endtask

    initial begin
        t_reset();
        t_bytes();
        t_set_clear();
        t_own_readback();
        t_mask();
        t_mask_side();
        t_reserved();
        t_hold();
        t_collision();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule